// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Multiplier

This block multiplies two 16-bit operands in one pass through a combinational array. Each operand carries its own select bit that says whether it is read as two's complement or as a plain unsigned number. Both operands are first widened by one bit, so a single 17-by-17 signed array covers every pairing: signed by signed, unsigned by unsigned, and either mixed order.

A second select bit switches the result from integer to fractional form. In fractional form the raw product is doubled, which turns a 1.15 by 1.15 product into a 1.31 result. Any doubled value that does not fit in the 32-bit result is clamped to the nearest end of the range, so (-1.0) x (-1.0) gives the largest positive value and does not wrap to a negative one. The result leaves through one output register by default, so it appears one clock after the operands are applied.

Top module: `mixmul_unit`

## Requirements
- R1: An operand whose sign-select bit is 1 is read as two's complement (0xFFFF is -1, 0x8000 is -32768). An operand whose sign-select bit is 0 is read as unsigned (0xFFFF is 65535, 0x8000 is 32768).
- R2: In integer mode (`frac_i`=0) with both operands signed, `prod_o` is the exact product as a 32-bit two's complement value.
- R3: In integer mode with both operands unsigned, `prod_o` is the exact product as a 32-bit unsigned value.
- R4: In integer mode with one operand signed and the other unsigned, in either order, `prod_o` is the exact product as a 32-bit two's complement value.
- R5: In fractional mode (`frac_i`=1), `prod_o` is twice the exact product whenever that doubled value fits in the 32-bit range, so bit 0 of the result is 0.
- R6: In fractional mode with both operands signed and both equal to 0x8000, `prod_o` is 0x7FFFFFFF.
- R7: In fractional mode, a doubled product outside the range is clamped. With both operands unsigned the range is 0 to 0xFFFFFFFF. Otherwise the range is -2^31 to 2^31-1, so the result becomes 0x7FFFFFFF above it and 0x80000000 below it.
- R8: `prod_o` is 0 while `rst_ni` is low and for the first clock edge after it goes high. After that, the result for the operands and modes present at a rising clock edge appears at `prod_o` after that edge and stays until the next edge.
- R9: If either operand is 0, `prod_o` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_sgn_i | input | 1 | 1: `a_i` is signed, 0: unsigned |
| b_sgn_i | input | 1 | 1: `b_i` is signed, 0: unsigned |
| frac_i | input | 1 | 1: fractional result (doubled and clamped), 0: integer |
| prod_o | output | 32 | Registered product |

## Verification
Random operands are run in all four sign pairings, once in integer mode and once in fractional mode. The random values are biased toward 0x0000, 0x7FFF, 0x8000 and 0xFFFF. A wrong widening bit changes only the pairings where the top operand bit is set, so mixed-order pairs show whether `a_sgn_i` and `b_sgn_i` have been swapped. Directed cases run 0x8000 and 0xFFFF against each other in every mode: 0xFFFF tells the signed reading of -1 apart from the unsigned reading of 65535, and 0x8000 squared in fractional mode tells correct clamping apart from wrap-around. A held-operand step checks the one-cycle timing, and reset checks confirm the output stays at zero.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

    // Per-operation interpretation of the operands and of the result
    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic frac;
    } mul_cfg_t;

    function automatic logic cfg_all_unsigned(mul_cfg_t c);
        return !c.a_sgn && !c.b_sgn;
    endfunction

endpackage

// File: rtl/mixmul_opext.sv
module mixmul_opext #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_i,
    input  logic         sgn_i,
    output logic [W:0]   ext_o
);
    // Top bit copies the operand MSB only when the operand is signed (R1)
    always_comb begin
        ext_o = {sgn_i & op_i[W-1], op_i};
    end
endmodule

// File: rtl/mixmul_array.sv
module mixmul_array #(
    parameter int EXT = 17
) (
    input  logic [EXT-1:0]   a_i,
    input  logic [EXT-1:0]   b_i,
    output logic [2*EXT-1:0] raw_o
);
    localparam int RAW = 2 * EXT;

    logic [RAW-1:0] a_wide;
    logic [RAW-1:0] row [EXT];
    logic [RAW-1:0] acc_d;

    assign a_wide = {{EXT{a_i[EXT-1]}}, a_i};

    // One partial-product row for each multiplier bit
    for (genvar i = 0; i < EXT; i++) begin : g_row
        assign row[i] = b_i[i] ? (a_wide << i) : '0;
    end

    // The top multiplier bit has negative weight in two's complement
    always_comb begin
        acc_d = '0;
        for (int k = 0; k < EXT - 1; k++) begin
            acc_d = acc_d + row[k];
        end
        acc_d = acc_d - row[EXT-1];
        raw_o = acc_d;
    end
endmodule

// File: rtl/mixmul_align.sv
module mixmul_align
    import mixmul_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic [2*OPW+1:0] raw_i,
    input  mul_cfg_t         cfg_i,
    output logic [2*OPW-1:0] res_o
);
    localparam int RAW = 2 * OPW + 2;
    localparam int RES = 2 * OPW;

    logic [RAW:0]   dbl_d;
    logic           uns_ovf_d;
    logic           sgn_ovf_d;
    logic [RES-1:0] sgn_sat_d;

    always_comb begin
        dbl_d     = {raw_i, 1'b0};
        // Unsigned pairs: any bit above the result width is overflow
        uns_ovf_d = |dbl_d[RAW:RES];
        // Signed range: the bits from RES-1 upward must all agree
        sgn_ovf_d = !((&dbl_d[RAW:RES-1]) || !(|dbl_d[RAW:RES-1]));
        sgn_sat_d = dbl_d[RAW] ? {1'b1, {(RES-1){1'b0}}}
                               : {1'b0, {(RES-1){1'b1}}};

        if (!cfg_i.frac) begin
            res_o = raw_i[RES-1:0];
        end else if (cfg_all_unsigned(cfg_i)) begin
            res_o = uns_ovf_d ? {RES{1'b1}} : dbl_d[RES-1:0];
        end else begin
            res_o = sgn_ovf_d ? sgn_sat_d : dbl_d[RES-1:0];
        end
    end
endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit
    import mixmul_pkg::*;
#(
    parameter int OPW     = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [OPW-1:0]   a_i,
    input  logic [OPW-1:0]   b_i,
    input  logic             a_sgn_i,
    input  logic             b_sgn_i,
    input  logic             frac_i,
    output logic [2*OPW-1:0] prod_o
);
    localparam int EXT = OPW + 1;
    localparam int RAW = 2 * EXT;
    localparam int RES = 2 * OPW;
    localparam logic [OPW-1:0] OP_MIN  = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [RES-1:0] RES_MAX = {1'b0, {(RES-1){1'b1}}};

    typedef struct packed {
        logic [RES-1:0] prod;
    } stage_t;

    mul_cfg_t       cfg;
    logic [EXT-1:0] a_ext;
    logic [EXT-1:0] b_ext;
    logic [RAW-1:0] raw;
    logic [RES-1:0] res;
    stage_t         stage_d;

    assign cfg = '{a_sgn: a_sgn_i, b_sgn: b_sgn_i, frac: frac_i};

    mixmul_opext #(.W(OPW)) u_ext_a (.op_i(a_i), .sgn_i(a_sgn_i), .ext_o(a_ext));
    mixmul_opext #(.W(OPW)) u_ext_b (.op_i(b_i), .sgn_i(b_sgn_i), .ext_o(b_ext));

    mixmul_array #(.EXT(EXT)) u_array (.a_i(a_ext), .b_i(b_ext), .raw_o(raw));

    mixmul_align #(.OPW(OPW)) u_align (.raw_i(raw), .cfg_i(cfg), .res_o(res));

    always_comb begin
        stage_d      = '0;
        stage_d.prod = res;
    end

    if (REG_OUT) begin : g_reg
        stage_t stage_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q <= '0;
            else         stage_q <= stage_d;
        end

        assign prod_o = stage_q.prod;

        // R8: output held at zero through reset
        a_r8_reset_zero: assert property (@(posedge clk_i)
            !rst_ni |=> prod_o == '0);

        // R6: (-1.0) x (-1.0) in fractional form clamps to the largest positive value
        a_r6_frac_min_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (frac_i && a_sgn_i && b_sgn_i && a_i == OP_MIN && b_i == OP_MIN)
            |=> prod_o == RES_MAX);

        // R9: zero operand gives zero result
        a_r9_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (a_i == '0 || b_i == '0) |=> prod_o == '0);

        // R5, R7: fractional results are even unless clamped high
        a_r5_frac_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
            frac_i |=> (prod_o[0] == 1'b0 || prod_o == RES_MAX || prod_o == '1));

        // R2: signed integer product of nonzero operands carries the XOR of the signs
        a_r2_sign_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!frac_i && a_sgn_i && b_sgn_i && a_i != '0 && b_i != '0)
            |=> prod_o[RES-1] == ($past(a_i[OPW-1]) ^ $past(b_i[OPW-1])));
    end else begin : g_comb
        assign prod_o = stage_d.prod;
    end
endmodule

// File: tb/sim_mixmul_unit.sv
`timescale 1ns/1ps
module sim_mixmul_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        a_sgn_i = 1'b0;
    logic        b_sgn_i = 1'b0;
    logic        frac_i = 1'b0;
    logic [31:0] prod_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk_i = ~clk_i;

    mixmul_unit u0 (
        .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
        .a_sgn_i(a_sgn_i), .b_sgn_i(b_sgn_i), .frac_i(frac_i), .prod_o(prod_o)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                            input logic as, input logic bs, input logic fr);
        longint va;
        longint vb;
        longint p;
        va = as ? longint'($signed(a)) : longint'(a);
        vb = bs ? longint'($signed(b)) : longint'(b);
        p  = va * vb;
        if (fr) begin
            p = p * 2;
            if (!as && !bs) begin
                if (p > 64'sd4294967295) p = 64'sd4294967295;
            end else begin
                if (p > 64'sd2147483647)  p = 64'sd2147483647;
                if (p < -64'sd2147483648) p = -64'sd2147483648;
            end
        end
        return p[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] a, input logic [15:0] b,
                       input logic as, input logic bs, input logic fr, input string req);
        @(negedge clk_i);
        a_i = a; b_i = b; a_sgn_i = as; b_sgn_i = bs; frac_i = fr;
        @(negedge clk_i);
        check(req, prod_o, ref_mul(a, b, as, bs, fr));
    endtask

    function automatic logic [15:0] pick();
        int unsigned r;
        r = $urandom % 10;
        case (r)
            0: return 16'h8000;
            1: return 16'hFFFF;
            2: return 16'h7FFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic string mode_tag(input logic as, input logic bs, input logic fr);
        if (fr)       return "R5_R7";
        if (as && bs) return "R2";
        if (!as && !bs) return "R3";
        return "R4";
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset state, operands applied while reset is held
        repeat (3) @(negedge clk_i);
        check("R8 reset", prod_o, 32'h0);
        a_i = 16'h1234; b_i = 16'h0101; a_sgn_i = 1'b1; b_sgn_i = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R8 held in reset", prod_o, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R8 first edge after reset", prod_o, ref_mul(16'h1234, 16'h0101, 1'b1, 1'b1, 1'b0));

        // R8: one-cycle latency
        @(negedge clk_i);
        a_i = 16'h0003; b_i = 16'h0005; a_sgn_i = 1'b0; b_sgn_i = 1'b0; frac_i = 1'b0;
        #1 check("R8 old value before edge", prod_o, ref_mul(16'h1234, 16'h0101, 1'b1, 1'b1, 1'b0));
        @(negedge clk_i);
        check("R8 new value after edge", prod_o, 32'd15);

        // R1: same bit patterns read signed and unsigned
        run(16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b0, "R1 signed ffff");
        check("R1 signed ffff value", prod_o, 32'hFFFFFFFE);
        run(16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0, "R1 unsigned ffff");
        check("R1 unsigned ffff value", prod_o, 32'h0001FFFE);
        run(16'h8000, 16'h0001, 1'b0, 1'b1, 1'b0, "R1 unsigned 8000");
        check("R1 unsigned 8000 value", prod_o, 32'h00008000);

        // R6: (-1.0) x (-1.0)
        run(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, "R6");
        check("R6 value", prod_o, 32'h7FFFFFFF);
        run(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, "R2 min squared");
        check("R2 min squared value", prod_o, 32'h40000000);

        // R7: clamping in each direction
        run(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R7 unsigned high");
        check("R7 unsigned high value", prod_o, 32'hFFFFFFFF);
        run(16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b1, "R7 mixed low");
        check("R7 mixed low value", prod_o, 32'h80000000);
        run(16'h7FFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, "R7 mixed high");
        check("R7 mixed high value", prod_o, 32'h7FFFFFFF);

        // R5: exact fractional value
        run(16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, "R5 half squared");
        check("R5 half squared value", prod_o, 32'h20000000);

        // R4: both mixed orders on the corner values
        run(16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R4 a signed");
        run(16'h8000, 16'hFFFF, 1'b0, 1'b1, 1'b0, "R4 b signed");

        // R9: zero operand in every mode
        for (int m = 0; m < 8; m++) begin
            run(16'h0000, 16'h8000, m[0], m[1], m[2], "R9 a zero");
            run(16'hFFFF, 16'h0000, m[0], m[1], m[2], "R9 b zero");
        end

        // Corner operands in every mode
        for (int m = 0; m < 8; m++) begin
            run(16'h8000, 16'h8000, m[0], m[1], m[2], mode_tag(m[0], m[1], m[2]));
            run(16'hFFFF, 16'hFFFF, m[0], m[1], m[2], mode_tag(m[0], m[1], m[2]));
            run(16'h8000, 16'hFFFF, m[0], m[1], m[2], mode_tag(m[0], m[1], m[2]));
            run(16'h7FFF, 16'h8000, m[0], m[1], m[2], mode_tag(m[0], m[1], m[2]));
        end

        // Random operands in every mode
        for (int m = 0; m < 8; m++) begin
            for (int n = 0; n < 150; n++) begin
                run(pick(), pick(), m[0], m[1], m[2], mode_tag(m[0], m[1], m[2]));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule